// File: doc/BRIEF.md
# Dual-Host Shared Byte Memory with Ownership Flag

This block is a byte-wide memory that two independent synchronous host buses can reach. A single ownership flag decides which host may use it. Each host has a select, an address, write data, and read and write strobes. It also has a registered read-data bus and an error pulse. A host may touch the array only while it holds the flag. The path of the other host is cut off from the array: its writes are dropped, its reads return zero, and every such attempt raises a one-cycle error pulse on that host's side.

Each host sees the array through its own decoded window. The upper address bits of that window are compared with a per-host base parameter, so one physical byte can sit at a different address for each host. Each host also has a flag location at its own decoded address. Reading that location is an atomic test-and-set: the read returns the old flag value and, if the memory was free, makes the reader the owner. A host can also claim by writing 1 to the location. The owner releases the memory by writing 0. The array holds 2**ADDR_W bytes. A full 8K part uses ADDR_W = 13; the default build uses a smaller depth.

Top module: `shared_ram_2host`

## Requirements
- R1: An owning host that writes a byte at window offset k reads the same byte back at offset k. Offsets cover 0 through 2**ADDR_W-1, and the window is selected when `hN_addr[15:ADDR_W]` equals the upper bits of that host's base.
- R2: After reset, both read-data buses and both error outputs are 0, and the flag is free, so the first flag read returns 0.
- R3: A read of a host's flag location returns the old flag in bit 0, with bits 7:1 zero. If the flag was free, that host becomes the owner from the next cycle, and later flag reads return 1.
- R4: If both hosts claim in the same cycle while the flag is free, host 0 becomes owner. A flag read by host 1 in that cycle returns 1.
- R5: A write to the flag location with bit 0 = 1 claims the memory when it is free. The same write has no effect when the other host holds it.
- R6: Only the owner can release the flag, by writing bit 0 = 0 to its flag location. The same write from the non-owner leaves the flag held.
- R7: A read of the array window by a host that is not the owner returns 0x00 and pulses that host's error output high for exactly one cycle.
- R8: A write to the array window by a host that is not the owner leaves the array unchanged and pulses that host's error output for one cycle.
- R9: After ownership passes from one host to the other, a byte written by host 0 at BASE0+k is read by host 1 at BASE1+k.
- R10: Read data appear in the cycle after the strobe and are 0 in every other cycle. A read of an address outside the window and the flag location returns 0 with no error.
- R11: When read and write strobes are both high, the access is a read and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h0_sel | input | 1 | Host 0 select |
| h0_addr | input | 16 | Host 0 address |
| h0_wdata | input | 8 | Host 0 write data |
| h0_rd | input | 1 | Host 0 read strobe |
| h0_wr | input | 1 | Host 0 write strobe |
| h0_rdata | output | 8 | Host 0 read data, one cycle after the strobe |
| h0_err | output | 1 | Host 0 access-denied pulse |
| h1_sel | input | 1 | Host 1 select |
| h1_addr | input | 16 | Host 1 address |
| h1_wdata | input | 8 | Host 1 write data |
| h1_rd | input | 1 | Host 1 read strobe |
| h1_wr | input | 1 | Host 1 write strobe |
| h1_rdata | output | 8 | Host 1 read data, one cycle after the strobe |
| h1_err | output | 1 | Host 1 access-denied pulse |

## Verification
The bench targets the same-cycle claim by both hosts. A design that samples the old flag for host 1 would hand host 1 a 0 while host 0 takes ownership, and both hosts would then believe they own the memory. It attempts releases and array writes from the non-owner. A design that gates these by address decode alone would free the flag under the owner or corrupt a byte that the owner reads back later. It drives read and write strobes together, and it reads the array through the second host's window after a handover. These catch a design that lets the write win or that decodes one shared base for both hosts. The bench also compares every cycle against a behavioural model, so an error pulse that lasts too long or read data that stay on the bus after a read both show up as a mismatch.

// File: rtl/shared_ram_2host.sv
module shared_ram_2host #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int HADDR_W = 16,
  parameter logic [HADDR_W-1:0] BASE0 = 16'h0000,
  parameter logic [HADDR_W-1:0] BASE1 = 16'h8000,
  parameter logic [HADDR_W-1:0] FLAG0 = 16'hF000,
  parameter logic [HADDR_W-1:0] FLAG1 = 16'hF000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h0_sel,
  input  logic [HADDR_W-1:0] h0_addr,
  input  logic [DATA_W-1:0]  h0_wdata,
  input  logic               h0_rd,
  input  logic               h0_wr,
  output logic [DATA_W-1:0]  h0_rdata,
  output logic               h0_err,
  input  logic               h1_sel,
  input  logic [HADDR_W-1:0] h1_addr,
  input  logic [DATA_W-1:0]  h1_wdata,
  input  logic               h1_rd,
  input  logic               h1_wr,
  output logic [DATA_W-1:0]  h1_rdata,
  output logic               h1_err
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic owned, owner;
  logic [1:0] win, flg, rd, wr, mine, claim, clr, deny;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wd, m_q;
  logic m_we;
  logic [1:0] mem_rd_q, flg_rd_q, flg_val_q, err_q;

  assign win[0] = h0_sel && (h0_addr[HADDR_W-1:ADDR_W] == BASE0[HADDR_W-1:ADDR_W]);
  assign win[1] = h1_sel && (h1_addr[HADDR_W-1:ADDR_W] == BASE1[HADDR_W-1:ADDR_W]);
  assign flg[0] = h0_sel && (h0_addr == FLAG0);
  assign flg[1] = h1_sel && (h1_addr == FLAG1);
  assign rd     = {h1_rd, h0_rd};
  assign wr     = {h1_wr && !h1_rd, h0_wr && !h0_rd};
  assign mine   = {owned && owner, owned && !owner};
  assign claim[0] = flg[0] && (rd[0] || (wr[0] && h0_wdata[0]));
  assign claim[1] = flg[1] && (rd[1] || (wr[1] && h1_wdata[0]));
  assign clr[0]   = flg[0] && wr[0] && !h0_wdata[0] && mine[0];
  assign clr[1]   = flg[1] && wr[1] && !h1_wdata[0] && mine[1];
  assign deny[0]  = win[0] && (h0_rd || h0_wr) && !mine[0];
  assign deny[1]  = win[1] && (h1_rd || h1_wr) && !mine[1];

  // Only the owner's path reaches the array.
  assign m_addr = owner ? h1_addr[ADDR_W-1:0] : h0_addr[ADDR_W-1:0];
  assign m_wd   = owner ? h1_wdata : h0_wdata;
  assign m_we   = owned && (owner ? (win[1] && wr[1]) : (win[0] && wr[0]));

  always_ff @(posedge clk) begin
    if (m_we) mem[m_addr] <= m_wd;
    m_q <= mem[m_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned <= 1'b0;
      owner <= 1'b0;
    end else if (clr[0] || clr[1]) begin
      owned <= 1'b0;
    end else if (!owned && claim[0]) begin
      owned <= 1'b1;
      owner <= 1'b0;
    end else if (!owned && claim[1]) begin
      owned <= 1'b1;
      owner <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_q  <= '0;
      flg_rd_q  <= '0;
      flg_val_q <= '0;
      err_q     <= '0;
    end else begin
      mem_rd_q  <= {win[1] && rd[1] && mine[1], win[0] && rd[0] && mine[0]};
      flg_rd_q  <= {flg[1] && rd[1], flg[0] && rd[0]};
      flg_val_q <= {owned || claim[0], owned};
      err_q     <= deny;
    end
  end

  assign h0_rdata = mem_rd_q[0] ? m_q : {{(DATA_W-1){1'b0}}, flg_rd_q[0] && flg_val_q[0]};
  assign h1_rdata = mem_rd_q[1] ? m_q : {{(DATA_W-1){1'b0}}, flg_rd_q[1] && flg_val_q[1]};
  assign h0_err   = err_q[0];
  assign h1_err   = err_q[1];

  p_nonowner_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win[1] && h1_rd && !mine[1]) |=> (h1_rdata == '0 && h1_err));
  p_nonowner_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win[0] && h0_wr && !mine[0]) |=> h0_err);
  p_tas_claims_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[0] && h0_rd && !owned) |=> (owned && !owner && h0_rdata == '0));
  p_tie_host0_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && claim[0] && flg[1] && h1_rd) |=> (h1_rdata == 1 && !owner));
  p_hold_without_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !clr[0] && !clr[1]) |=> (owned && $stable(owner)));
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!deny[0]) |=> !h0_err);
endmodule

// File: tb/tb_shared_ram_2host.sv
module tb_shared_ram_2host;
  localparam int CLK_P = 10;
  localparam int AW = 11;
  localparam logic [15:0] B0 = 16'h0000, B1 = 16'h8000, FL = 16'hF000;

  logic clk = 0, rst_n = 0;
  logic h0_sel = 0, h0_rd = 0, h0_wr = 0, h1_sel = 0, h1_rd = 0, h1_wr = 0;
  logic [15:0] h0_addr = 0, h1_addr = 0;
  logic [7:0] h0_wdata = 0, h1_wdata = 0;
  logic [7:0] h0_rdata, h1_rdata;
  logic h0_err, h1_err;

  shared_ram_2host #(.ADDR_W(AW), .BASE0(B0), .BASE1(B1), .FLAG0(FL), .FLAG1(FL)) dut (
    .clk, .rst_n, .h0_sel, .h0_addr, .h0_wdata, .h0_rd, .h0_wr, .h0_rdata, .h0_err,
    .h1_sel, .h1_addr, .h1_wdata, .h1_rd, .h1_wr, .h1_rdata, .h1_err);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  string req = "R2";
  bit m_owned = 0;
  int m_owner = 0;
  logic [7:0] m_mem [int];
  logic [7:0] e_rd0 = 0, e_rd1 = 0;
  logic e_er0 = 0, e_er1 = 0;

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdmem(int a);
    return m_mem.exists(a) ? m_mem[a] : 8'h00;
  endfunction

  task automatic tick();
    bit w0, w1, f0, f1, r0, r1, wr0, wr1, c0, c1, cl0, cl1, own0, own1;
    logic [7:0] n0, n1;
    w0 = h0_sel && h0_addr[15:AW] == B0[15:AW];
    w1 = h1_sel && h1_addr[15:AW] == B1[15:AW];
    f0 = h0_sel && h0_addr == FL;  f1 = h1_sel && h1_addr == FL;
    r0 = h0_rd; r1 = h1_rd;
    wr0 = h0_wr && !h0_rd; wr1 = h1_wr && !h1_rd;
    own0 = m_owned && m_owner == 0; own1 = m_owned && m_owner == 1;
    c0 = f0 && (r0 || (wr0 && h0_wdata[0]));
    c1 = f1 && (r1 || (wr1 && h1_wdata[0]));
    cl0 = f0 && wr0 && !h0_wdata[0] && own0;
    cl1 = f1 && wr1 && !h1_wdata[0] && own1;
    n0 = 0; n1 = 0;
    if (r0 && f0) n0 = {7'd0, m_owned};
    else if (r0 && w0 && own0) n0 = rdmem(int'(h0_addr[AW-1:0]));
    if (r1 && f1) n1 = {7'd0, m_owned || c0};
    else if (r1 && w1 && own1) n1 = rdmem(int'(h1_addr[AW-1:0]));
    @(posedge clk);
    e_rd0 = n0; e_rd1 = n1;
    e_er0 = w0 && (h0_rd || h0_wr) && !own0;
    e_er1 = w1 && (h1_rd || h1_wr) && !own1;
    if (wr0 && w0 && own0) m_mem[int'(h0_addr[AW-1:0])] = h0_wdata;
    if (wr1 && w1 && own1) m_mem[int'(h1_addr[AW-1:0])] = h1_wdata;
    if (cl0 || cl1) m_owned = 0;
    else if (!m_owned && c0) begin m_owned = 1; m_owner = 0; end
    else if (!m_owned && c1) begin m_owned = 1; m_owner = 1; end
    #2;
    cmp("h0_rdata", h0_rdata, e_rd0);
    cmp("h1_rdata", h1_rdata, e_rd1);
    cmp("h0_err", {7'd0, h0_err}, {7'd0, e_er0});
    cmp("h1_err", {7'd0, h1_err}, {7'd0, e_er1});
  endtask

  task automatic idle();
    h0_sel = 0; h0_rd = 0; h0_wr = 0; h1_sel = 0; h1_rd = 0; h1_wr = 0;
  endtask

  task automatic a0(logic [15:0] ad, logic [7:0] d, logic r, logic w);
    h0_sel = 1; h0_addr = ad; h0_wdata = d; h0_rd = r; h0_wr = w;
  endtask

  task automatic a1(logic [15:0] ad, logic [7:0] d, logic r, logic w);
    h1_sel = 1; h1_addr = ad; h1_wdata = d; h1_rd = r; h1_wr = w;
  endtask

  task automatic op0(logic [15:0] ad, logic [7:0] d, logic r, logic w);
    idle(); a0(ad, d, r, w); tick(); idle(); tick();
  endtask

  task automatic op1(logic [15:0] ad, logic [7:0] d, logic r, logic w);
    idle(); a1(ad, d, r, w); tick(); idle(); tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    req = "R2";
    cmp("h0_rdata reset", h0_rdata, 8'h00);
    cmp("h1_err reset", {7'd0, h1_err}, 8'h00);
    @(negedge clk); rst_n = 1; @(posedge clk); #2;
    req = "R8"; op1(B1 + 16'd5, 8'hEE, 0, 1);
    req = "R7"; op0(B0 + 16'd5, 8'h00, 1, 0);
    req = "R3"; op0(FL, 8'h00, 1, 0);
    op0(FL, 8'h00, 1, 0);
    op1(FL, 8'h00, 1, 0);
    req = "R1";
    op0(B0 + 16'd0, 8'h11, 0, 1);
    op0(B0 + 16'd5, 8'h55, 0, 1);
    op0(B0 + 16'd2047, 8'hA7, 0, 1);
    for (int i = 0; i < 8; i++) op0(B0 + 16'(100 + i), 8'(i * 37 + 3), 0, 1);
    op0(B0 + 16'd0, 8'h00, 1, 0);
    op0(B0 + 16'd2047, 8'h00, 1, 0);
    for (int i = 0; i < 8; i++) op0(B0 + 16'(100 + i), 8'h00, 1, 0);
    req = "R11"; op0(B0 + 16'd5, 8'h99, 1, 1);
    op0(B0 + 16'd5, 8'h00, 1, 0);
    req = "R8"; op1(B1 + 16'd5, 8'h77, 0, 1);
    op0(B0 + 16'd5, 8'h00, 1, 0);
    req = "R7"; op1(B1 + 16'd0, 8'h00, 1, 0);
    req = "R6"; op1(FL, 8'h00, 0, 1);
    op1(FL, 8'h00, 1, 0);
    req = "R5"; op1(FL, 8'h01, 0, 1);
    op0(B0 + 16'd0, 8'h00, 1, 0);
    req = "R6"; op0(FL, 8'h00, 0, 1);
    req = "R5"; op1(FL, 8'h01, 0, 1);
    op1(FL, 8'h00, 1, 0);
    req = "R9"; op1(B1 + 16'd5, 8'h00, 1, 0);
    op1(B1 + 16'd2047, 8'h00, 1, 0);
    op0(B0 + 16'd5, 8'h00, 1, 0);
    req = "R10"; op1(16'h4000, 8'h00, 1, 0);
    idle(); a1(B1 + 16'd0, 8'h00, 1, 0); tick(); a1(B1 + 16'd2047, 8'h00, 1, 0); tick();
    idle(); tick(); tick();
    req = "R6"; op1(FL, 8'h00, 0, 1);
    req = "R4";
    idle(); a0(FL, 8'h00, 1, 0); a1(FL, 8'h00, 1, 0); tick(); idle(); tick();
    op1(B1 + 16'd5, 8'h00, 1, 0);
    op0(FL, 8'h00, 0, 1);
    idle(); a0(FL, 8'h01, 0, 1); a1(FL, 8'h01, 0, 1); tick(); idle(); tick();
    op1(FL, 8'h00, 1, 0);
    op0(B0 + 16'd5, 8'h00, 1, 0);
    op0(FL, 8'h00, 0, 1);
    idle(); a0(FL, 8'h00, 1, 0); a1(FL, 8'h00, 0, 1); tick(); idle(); tick();
    op1(FL, 8'h00, 1, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule